// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Window

This block merges a set of interrupt request lines (32 by default) into a single processor interrupt output. Each line has a sticky status bit that records a request. Each line also has an enable bit that masks it. A priority encoder reports the lowest-numbered line that is both recorded and enabled. Software reaches the block through eight 32-bit word registers in a 32-byte window. The window is served by a simple register bus made of an address, write data, a write strobe, a read strobe and registered read data.

A typical interrupt service routine reads the vector word and services that line. It then clears the line's status bit through the acknowledge word. Write-one-to-set and write-one-to-clear aliases of the enable register let software mask or unmask single lines without a read-modify-write sequence. A two-bit master enable gates the output, and both of its bits must be set for the output to rise. Each line's sense type is fixed when the block is built: level for most lines, or rising edge for lines selected by a parameter mask.

The register bus is plain control traffic, so it has no valid/ready handshake. A write takes effect on the clock edge where the write strobe is high. A read puts its word on the read data port on the clock edge where the read strobe is high. That value then holds until the next read. Bit n of every line-wide register belongs to line n.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the status, enable and master enable registers read 0, the read data port is 0, and `irq_out` is low.
- R2: A level-sensed line sets its status bit (word offset 0x00, bit n = line n) on any clock edge where the line is high. The bit stays set after the line falls, until it is acknowledged.
- R3: Writing the acknowledge word (offset 0x0C) clears each status bit whose written bit is 1 and leaves the other status bits unchanged. If the line is still high, its bit reads 0 for one cycle and is then captured again, so `irq_out` drops for exactly one cycle.
- R4: A write to the enable word (offset 0x08) replaces all enable bits with the written value.
- R5: A write to the set-enable word (offset 0x10) sets only the enable bits written as 1. A write to the clear-enable word (offset 0x14) clears only the enable bits written as 1.
- R6: The pending word (offset 0x04) reads status AND enable. Writes to it have no effect.
- R7: `irq_out` is high exactly when master enable bits 1 and 0 (word offset 0x1C) are both 1 and at least one pending bit is 1.
- R8: The vector word (offset 0x18) reads the index of the lowest-numbered pending line, zero-extended. It reads 0xFFFFFFFF when nothing is pending.
- R9: The acknowledge, set-enable and clear-enable words read as 0. Writes to the status, pending and vector words change no register.
- R10: A line whose bit is set in the `SENSE_EDGE` parameter sets its status bit only on a low-to-high transition. If the line is held high after an acknowledge, the bit is not captured again.
- R11: A read returns the addressed word on `bus_rdata` on the clock edge where `bus_rd` is high, and `bus_rdata` holds that value until the next read. An access whose address bits [1:0] are not 00 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | N_LINES | Interrupt request inputs, synchronous to clk |
| bus_addr | input | 5 | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Processor interrupt request |

## Verification
The bench acknowledges a level line while the line is still high and looks for the single-cycle dip on `irq_out`. A design that gave capture priority over the clear would never drop the output, and one that lost the capture would leave the request dead. It acknowledges a held edge-sensed line and expects no new capture, which catches a design that treats every line as level-sensed. It checks the vector word with several lines pending and with none pending, which exposes a design that picks the highest line or returns 0 for the empty case. It also applies the set and clear aliases to a mixed enable pattern and expects the untouched bits to survive, which a design that writes the aliases through as a plain enable write would fail.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int WIN_ADDR_W = 5;

  // word index = byte address [4:2]; the offsets are fixed for software
  typedef enum logic [2:0] {
    SEL_STATUS  = 3'd0,
    SEL_PENDING = 3'd1,
    SEL_ENABLE  = 3'd2,
    SEL_ACK     = 3'd3,
    SEL_SETEN   = 3'd4,
    SEL_CLREN   = 3'd5,
    SEL_VECTOR  = 3'd6,
    SEL_MASTER  = 3'd7
  } word_sel_e;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int                 N_LINES    = 32,
  parameter logic [N_LINES-1:0] SENSE_EDGE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines,
  input  logic [N_LINES-1:0] ack_mask,
  output logic [N_LINES-1:0] status
);
  logic [N_LINES-1:0] hit;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    if (SENSE_EDGE[i]) begin : g_edge
      logic prev;
      always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lines[i];
      end
      assign hit[i] = lines[i] & ~prev;
    end else begin : g_level
      assign hit[i] = lines[i];
    end
  end

  // acknowledge wins over a capture in the same cycle (R3)
  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status | hit) & ~ack_mask;
  end
endmodule

// File: rtl/irq_enable.sv
module irq_enable #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_full,
  input  logic               wr_set,
  input  logic               wr_clr,
  input  logic [N_LINES-1:0] wvalue,
  output logic [N_LINES-1:0] enable
);
  always_ff @(posedge clk) begin
    if (!rst_n)       enable <= '0;
    else if (wr_full) enable <= wvalue;
    else if (wr_set)  enable <= enable | wvalue;
    else if (wr_clr)  enable <= enable & ~wvalue;
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N_LINES = 32,
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] pending,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  // scan from the top down so the lowest set line is written last
  always_comb begin
    idx = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (pending[i]) idx = IDX_W'(i);
    end
    any = |pending;
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int                 N_LINES    = 32,
  parameter int                 DATA_W     = 32,
  parameter logic [N_LINES-1:0] SENSE_EDGE = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_LINES-1:0]    irq_lines,
  input  logic [WIN_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  irq_out
);
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  word_sel_e          sel;
  logic               aligned, wr_hit, rd_hit;
  logic [N_LINES-1:0] wline, ack_mask, status, enable, pending;
  logic [1:0]         master_en;
  logic               any_pend;
  logic [IDX_W-1:0]   pend_idx;
  logic [DATA_W-1:0]  vector_word, rd_word;

  assign sel     = word_sel_e'(bus_addr[WIN_ADDR_W-1:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_hit  = bus_wr & aligned;
  assign rd_hit  = bus_rd & aligned;
  assign wline   = bus_wdata[N_LINES-1:0];

  assign ack_mask = (wr_hit && sel == SEL_ACK) ? wline : '0;

  irq_capture #(.N_LINES(N_LINES), .SENSE_EDGE(SENSE_EDGE)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (irq_lines),
    .ack_mask (ack_mask),
    .status   (status)
  );

  irq_enable #(.N_LINES(N_LINES)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_full (wr_hit && sel == SEL_ENABLE),
    .wr_set  (wr_hit && sel == SEL_SETEN),
    .wr_clr  (wr_hit && sel == SEL_CLREN),
    .wvalue  (wline),
    .enable  (enable)
  );

  assign pending = status & enable;

  irq_prio #(.N_LINES(N_LINES)) u_prio (
    .pending (pending),
    .any     (any_pend),
    .idx     (pend_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                         master_en <= 2'b00;
    else if (wr_hit && sel == SEL_MASTER) master_en <= bus_wdata[1:0];
  end

  assign irq_out     = (&master_en) & any_pend;
  assign vector_word = any_pend ? DATA_W'(pend_idx) : '1;

  always_comb begin
    unique case (sel)
      SEL_STATUS:  rd_word = DATA_W'(status);
      SEL_PENDING: rd_word = DATA_W'(pending);
      SEL_ENABLE:  rd_word = DATA_W'(enable);
      SEL_VECTOR:  rd_word = vector_word;
      SEL_MASTER:  rd_word = DATA_W'(master_en);
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int N_LINES = 32,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [4:0]         bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [N_LINES-1:0] status,
  input logic [N_LINES-1:0] enable,
  input logic [N_LINES-1:0] ack_mask,
  input logic               any_pend,
  input logic [1:0]         master_en,
  input logic [DATA_W-1:0]  vector_word,
  input logic               irq_out
);
  // R7: output needs both master bits
  p_irq_needs_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (master_en == 2'b11));

  // R2: a status bit only drops through an acknowledge
  p_status_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~status) & ~$past(ack_mask)) == '0));

  // R3: acknowledged bits read zero the next cycle
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'h0C) |=> ((status & $past(bus_wdata[N_LINES-1:0])) == '0));

  // R5: set alias only adds bits
  p_set_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'h10) |=>
      (enable == ($past(enable) | $past(bus_wdata[N_LINES-1:0]))));

  // R5: clear alias only removes bits
  p_clr_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'h14) |=>
      (enable == ($past(enable) & ~$past(bus_wdata[N_LINES-1:0]))));

  // R8: empty vector reads all ones
  p_vec_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |-> (vector_word == '1));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .status      (status),
  .enable      (enable),
  .ack_mask    (ack_mask),
  .any_pend    (any_pend),
  .master_en   (master_en),
  .vector_word (vector_word),
  .irq_out     (irq_out)
);

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
  localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08, A_ACK = 5'h0C,
                         A_SET = 5'h10, A_CLR = 5'h14, A_VEC = 5'h18, A_MST = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_vec_ctrl #(.SENSE_EDGE(32'h8000_0000)) uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] m);
    irq_lines = irq_lines | m; @(negedge clk);
    irq_lines = irq_lines & ~m; @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 irq", {31'h0, irq_out}, 32'h0);
    rd(A_STAT, v); chk("R1 status", v, 32'h0);
    rd(A_EN, v);   chk("R1 enable", v, 32'h0);
    rd(A_MST, v);  chk("R1 master", v, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    pulse(32'h20);
    rd(A_STAT, v); chk("R2 sticky", v, 32'h20);
    wr(A_ACK, 32'h1);
    rd(A_STAT, v); chk("R3 other bit kept", v, 32'h20);
    wr(A_ACK, 32'h20);
    rd(A_STAT, v); chk("R3 acked", v, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr(A_EN, 32'hF0);  rd(A_EN, v); chk("R4 write", v, 32'hF0);
    wr(A_EN, 32'h0F);  rd(A_EN, v); chk("R4 replace", v, 32'h0F);
    wr(A_SET, 32'h100); rd(A_EN, v); chk("R5 set", v, 32'h10F);
    wr(A_CLR, 32'h3);   rd(A_EN, v); chk("R5 clear", v, 32'h10C);
  endtask

  task automatic t_pending;
    logic [31:0] v;
    wr(A_EN, 32'h108);
    pulse(32'h10C);
    rd(A_PEND, v); chk("R6 pending", v, 32'h108);
    wr(A_PEND, 32'h0);
    rd(A_PEND, v); chk("R6 write ignored", v, 32'h108);
    rd(A_VEC, v);  chk("R8 lowest", v, 32'h3);
    wr(A_MST, 32'h1); chk("R7 half master", {31'h0, irq_out}, 32'h0);
    wr(A_MST, 32'h2); chk("R7 other half", {31'h0, irq_out}, 32'h0);
    wr(A_MST, 32'h3); chk("R7 on", {31'h0, irq_out}, 32'h1);
    rd(A_MST, v);  chk("R7 master read", v, 32'h3);
    wr(A_ACK, 32'h8);
    rd(A_VEC, v);  chk("R8 next", v, 32'h8);
    wr(A_ACK, 32'hFFFF_FFFF);
    rd(A_VEC, v);  chk("R8 none", v, 32'hFFFF_FFFF);
    chk("R7 idle", {31'h0, irq_out}, 32'h0);
  endtask

  task automatic t_readzero;
    logic [31:0] v;
    rd(A_ACK, v); chk("R9 ack reads 0", v, 32'h0);
    rd(A_SET, v); chk("R9 set reads 0", v, 32'h0);
    rd(A_CLR, v); chk("R9 clr reads 0", v, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_VEC, 32'h5);
    rd(A_STAT, v); chk("R9 status write ignored", v, 32'h0);
    rd(A_EN, v);   chk("R9 enable untouched", v, 32'h108);
  endtask

  task automatic t_ack_held;
    wr(A_EN, 32'h10);
    irq_lines[4] = 1'b1; @(negedge clk);
    chk("R3 raised", {31'h0, irq_out}, 32'h1);
    wr(A_ACK, 32'h10);
    chk("R3 dip", {31'h0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R3 recapture", {31'h0, irq_out}, 32'h1);
    irq_lines[4] = 1'b0;
    wr(A_ACK, 32'h10);
    chk("R3 cleared", {31'h0, irq_out}, 32'h0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(A_EN, 32'h8000_0000);
    irq_lines[31] = 1'b1; @(negedge clk);
    rd(A_STAT, v); chk("R10 edge capture", v, 32'h8000_0000);
    wr(A_ACK, 32'h8000_0000);
    @(negedge clk);
    rd(A_STAT, v); chk("R10 held no recapture", v, 32'h0);
    chk("R10 irq low", {31'h0, irq_out}, 32'h0);
    irq_lines[31] = 1'b0; @(negedge clk);
    irq_lines[31] = 1'b1; @(negedge clk);
    rd(A_STAT, v); chk("R10 new edge", v, 32'h8000_0000);
    irq_lines[31] = 1'b0;
    wr(A_ACK, 32'h8000_0000);
  endtask

  task automatic t_rdata;
    logic [31:0] v;
    rd(A_EN, v); chk("R11 read", v, 32'h8000_0000);
    wr(A_EN, 32'h55);
    @(negedge clk);
    chk("R11 holds", bus_rdata, 32'h8000_0000);
    wr(5'h09, 32'hAA);
    rd(A_EN, v); chk("R11 misaligned write ignored", v, 32'h55);
    rd(5'h0A, v); chk("R11 misaligned read ignored", v, 32'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_enable();
    t_pending();
    t_readzero();
    t_ack_held();
    t_edge();
    t_rdata();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule